// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches a set of general-purpose port input pins, by default 32, and records edges on them as pending events. Each pin has its own sense bit. With the bit clear, a rise or a fall on the pin records an event. With the bit set, only a high-to-low transition records one. Every pin input passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier.

Pending events are stored whether or not the pin is enabled. A per-pin enable bit decides which stored events drive the single combined interrupt line toward the parent interrupt controller. Software acknowledges an event by writing a one to its bit. Software reaches the three registers through a plain word port with valid, write, address and data signals. The port takes one access per cycle and has no back-pressure. Read data comes back one cycle after the request, marked by a one-cycle read-valid strobe.

In every register, pin n occupies bit 31−n, so pin 0 is the most significant bit.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, all three registers read as zero and `irq_o` is low. A read of any offset other than 0x0C, 0x10 or 0x14 returns zero.
- R2: Pin n appears in bit 31−n of the pending, enable and sense registers (pin 0 in bit 31, pin 31 in bit 0).
- R3: With a pin's sense bit at 0 (any-edge mode), a 0→1 change and a 1→0 change on the pin each set its pending bit. The bit is set within four clock edges after the pin changes.
- R4: With a pin's sense bit at 1 (falling-only mode), a 1→0 change sets its pending bit and a 0→1 change leaves it clear.
- R5: Pending bits are set whether the pin's enable bit (offset 0x10) is 1 or 0. An enable bit of 1 lets that pin's pending event reach `irq_o`; 0 blocks it.
- R6: A write to offset 0x0C clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R7: If an edge on a pin is detected in the same cycle as a clearing write to that pin's pending bit, the bit stays set.
- R8: `irq_o` is registered. It equals the OR over all pins of (pending AND enable) as of the previous clock edge, so enabling a pin that already holds a pending event raises `irq_o` one cycle later.
- R9: Offsets 0x10 (enable) and 0x14 (sense) read back the full word last written. Offset 0x0C reads the pending bits.
- R10: Read data is presented on `bus_rdata` with `bus_rvalid` high in the cycle after an accepted read. `bus_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 32 | Asynchronous port pin inputs, index n is pin n |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Pulses one cycle after a read request |
| irq_o | output | 1 | Combined interrupt request to the parent controller |

## Verification
The bench drives a clearing write in exactly the cycle in which a new edge is detected. A design that gives the clear priority would lose that event and read back zero. It drives rising edges in falling-only mode, where a design that ignores the sense bit would record a spurious event. It also stores events while a pin is disabled, then enables the pin. A design that gates latching with the enable bit would never raise the interrupt, and one that takes the wrong bit order would show the event in the mirrored bit. It writes zeros to the pending register to show that nothing is cleared, and reads unmapped offsets, where a decoder that aliases would return register contents.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_EN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 8'h14;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_EN,
    SEL_SENSE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PEND:  return SEL_PEND;
      OFS_EN:    return SEL_EN;
      OFS_SENSE: return SEL_SENSE;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_o <= '0;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
    end
  end
endmodule

// File: rtl/pei_edge_latch.sv
module pei_edge_latch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic went_up, went_down;
    assign went_up   = sync_i[n] & ~prev_q[n];
    assign went_down = ~sync_i[n] & prev_q[n];
    assign hit[n]    = went_down | (went_up & ~sense_i[n]);

    always_ff @(posedge clk) begin
      if (!rst_n)      pend_o[n] <= 1'b0;
      else if (hit[n]) pend_o[n] <= 1'b1;
      else if (clr_i[n]) pend_o[n] <= 1'b0;
    end

    // R7: a detected edge always leaves the bit set, clear or not
    assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] |=> pend_o[n]);
    // R4: in falling-only mode a new event must come from a falling input
    assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_o[n]) && $past(sense_i[n])) |-> $past(prev_q[n] && !sync_i[n]));
    // R6: without a clear a pending bit stays set
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[n] && !clr_i[n]) |=> pend_o[n]);
    // R3: no event appears without an input change
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o[n]) |-> $past(sync_i[n] != prev_q[n]));
  end
endmodule

// File: rtl/pei_regs.sv
module pei_regs
  import pei_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] clr_o
);
  localparam int TOP = REG_W - 1;

  reg_sel_e            sel;
  logic                wr, rd;
  logic [NUM_PINS-1:0] wpin;
  logic [NUM_PINS-1:0] rpin;
  logic [REG_W-1:0]    rword;
  logic                sel_none_q;

  assign sel = decode_ofs(bus_addr);
  assign wr  = bus_valid & bus_write;
  assign rd  = bus_valid & ~bus_write;

  for (genvar n = 0; n < REG_W; n++) begin : g_map
    if (n < NUM_PINS) begin : g_live
      assign wpin[n]       = bus_wdata[TOP-n];
      assign rword[TOP-n]  = rpin[n];
    end else begin : g_pad
      assign rword[TOP-n] = 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND:  rpin = pend_i;
      SEL_EN:    rpin = en_o;
      SEL_SENSE: rpin = sense_o;
      default:   rpin = '0;
    endcase
  end

  assign clr_o = (wr && sel == SEL_PEND) ? wpin : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o    <= '0;
      sense_o <= '0;
    end else if (wr) begin
      if (sel == SEL_EN)    en_o    <= wpin;
      if (sel == SEL_SENSE) sense_o <= wpin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      sel_none_q <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      sel_none_q <= (sel == SEL_NONE);
      if (rd) bus_rdata <= rword;
    end
  end

  // R1: unmapped offsets read as zero
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && sel_none_q) |-> (bus_rdata == '0));
  // R10: rvalid is a single-cycle answer to a read
  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  // R10: read data only changes after a read request
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pei_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] en;
  logic [NUM_PINS-1:0] sense;
  logic [NUM_PINS-1:0] clr;

  pei_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (pin_sync)
  );

  pei_edge_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (pin_sync),
    .sense_i (sense),
    .clr_i   (clr),
    .pend_o  (pend)
  );

  pei_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pend_i     (pend),
    .en_o       (en),
    .sense_o    (sense),
    .clr_o      (clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(pend & en);
  end

  // R8: an enabled pending event drives the request on the next edge
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en)) |=> irq_o);
  // R5: with nothing enabled and pending the request drops
  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |=> !irq_o);
endmodule

// File: tb/pin_edge_irq_bench.sv
module pin_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_PEND = 8'h0C, A_EN = 8'h10, A_SENSE = 8'h14;

  // {pin[4:0], falling_only, enabled, new_level, exp_pending, exp_irq}
  localparam logic [9:0] VEC [8] = '{
    {5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd31, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd17, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd17, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  always #2.5 clk = ~clk;

  pin_edge_irq u_pin_edge_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (pins),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv;
    logic [31:0] bitv;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state and unmapped reads
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    bread(A_PEND, rv);  check("R1 pending reset", rv, 32'd0);
    bread(A_EN, rv);    check("R1 enable reset", rv, 32'd0);
    bread(A_SENSE, rv); check("R1 sense reset", rv, 32'd0);

    // Vector table: R2 R3 R4 R5 R8
    for (int i = 0; i < 8; i++) begin
      int p;
      p = int'(VEC[i][9:5]);
      bitv = 32'h8000_0000 >> p;
      bwrite(A_SENSE, VEC[i][4] ? bitv : 32'd0);
      bwrite(A_EN, VEC[i][3] ? bitv : 32'd0);
      bwrite(A_PEND, 32'hFFFF_FFFF);
      @(negedge clk);
      pins[p] = VEC[i][2];
      idle(6);
      bread(A_PEND, rv);
      check($sformatf("R2/R3/R4 vec %0d pending", i), rv, VEC[i][1] ? bitv : 32'd0);
      check($sformatf("R5/R8 vec %0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
    end

    // R9 read-back
    bwrite(A_EN, 32'hA5A5_0F0F);
    bread(A_EN, rv);    check("R9 enable readback", rv, 32'hA5A5_0F0F);
    bwrite(A_SENSE, 32'h1234_5678);
    bread(A_SENSE, rv); check("R9 sense readback", rv, 32'h1234_5678);
    bwrite(A_EN, 32'd0);
    bwrite(A_SENSE, 32'd0);

    // R1 unmapped offsets
    bread(8'h00, rv); check("R1 unmapped 0x00", rv, 32'd0);
    bread(8'h18, rv); check("R1 unmapped 0x18", rv, 32'd0);

    // R6 write-one-to-clear
    bwrite(A_PEND, 32'hFFFF_FFFF);
    @(negedge clk);
    pins[3] = 1'b1; pins[9] = 1'b1;
    idle(6);
    bread(A_PEND, rv); check("R6 two events", rv, (32'd1 << 28) | (32'd1 << 22));
    bwrite(A_PEND, 32'd1 << 28);
    bread(A_PEND, rv); check("R6 one cleared", rv, 32'd1 << 22);
    bwrite(A_PEND, 32'd0);
    bread(A_PEND, rv); check("R6 zero write keeps", rv, 32'd1 << 22);

    // R8 enabling a stored event
    check("R8 masked no irq", {31'd0, irq_o}, 32'd0);
    bwrite(A_EN, 32'd1 << 22);
    @(negedge clk);
    check("R8 irq after enable", {31'd0, irq_o}, 32'd1);
    bwrite(A_PEND, 32'd1 << 22);
    @(negedge clk);
    check("R8 irq after clear", {31'd0, irq_o}, 32'd0);
    bwrite(A_EN, 32'd0);

    // R7 edge wins over same-cycle clear (pin 12 -> bit 19)
    @(negedge clk);
    pins[12] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_PEND; bus_wdata = 32'd1 << 19;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    idle(2);
    bread(A_PEND, rv); check("R7 edge beats clear", rv, 32'd1 << 19);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule